// File: doc/BRIEF.md
# Redundant Reference Clock Selector

This block decides which of two candidate clock inputs serves as the reference for a downstream PLL. It drives the select line of an external glitch-free clock multiplexer. It also drives a separate indicator that reports which input is actually in use. All of its logic runs in one system clock domain.

The decision draws on four things:
- a primary-select level, which names the preferred input;
- a mode level, which is manual when low and automatic when high;
- two latched failure flags from a clock monitor;
- an active-low alarm-clear strobe.

In manual mode the primary input is always the reference. In automatic mode a failed primary is replaced by the secondary, provided the secondary is healthy. The selection does not fall back by itself when the primary recovers. An alarm clear or a new primary-select level restores the primary.

Top module: `refclk_selector`

## Requirements
- R1: While `rst_n` is low, `mux_sel_o` and `in_use_o` are 0. Within 5 clock cycles after reset release, both equal the level on `prim_sel_i`. A high on `prim_sel_i` names input 1 as primary, and a low names input 0.
- R2: In manual mode (`auto_mode_i` low), `mux_sel_o` follows the primary even while `fail_i` flags that input as failed.
- R3: A change of `prim_sel_i` moves `mux_sel_o` to the new primary within 4 cycles, in either mode.
- R4: In automatic mode, suppose the current reference is the primary, its bit of `fail_i` is set (bit k = 1 means input k has failed), and the other bit is clear. Then `mux_sel_o` switches to the secondary on the next clock edge.
- R5: In automatic mode with both `fail_i` bits set, `mux_sel_o` keeps its value.
- R6: After an automatic switch to the secondary, `mux_sel_o` stays on the secondary when the primary's failure bit clears.
- R7: `in_use_o` equals the value `mux_sel_o` had one cycle earlier, so the indicator changes only after the select has switched.
- R8: A high-to-low transition on `alarm_clr_n_i` makes the primary the reference within 5 cycles.
- R9: A high-to-low transition on `alarm_clr_n_i` while both `fail_i` bits are set selects input 0, whatever the level of `prim_sel_i`.
- R10: A low-to-high transition on `alarm_clr_n_i` leaves `mux_sel_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| prim_sel_i | input | 1 | Primary choice (asynchronous): 1 selects input 1 |
| auto_mode_i | input | 1 | Mode (asynchronous): 0 is manual, 1 is automatic |
| alarm_clr_n_i | input | 1 | Alarm clear (asynchronous); a falling edge acts |
| fail_i | input | 2 | Latched failure flags from the monitor, synchronous to `clk` |
| mux_sel_o | output | 1 | Select line to the clock multiplexer |
| in_use_o | output | 1 | Indicator of the input in use |

## Verification
The properties assume that `fail_i` comes from a monitor in the same clock domain, so it is sampled without synchronisation and is stable around each edge. The three asynchronous levels are judged only after their two-flop synchronisers. This means the properties are written against the synchronised copies and the derived edge pulses, not against the raw pins. The bench changes every input at the falling clock edge. It holds each alarm-clear pulse low for several cycles, so the synchronisers always capture it. Before each alarm clear it sets `fail_i` to the state a monitor would present at that moment.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic {REF_IN0 = 1'b0, REF_IN1 = 1'b1} ref_t;

  function automatic ref_t other(input ref_t r);
    return (r == REF_IN0) ? REF_IN1 : REF_IN0;
  endfunction
endpackage

// File: rtl/refsel_sync.sv
// Register pipeline with per-bit reset value; used for synchronisers and
// one-cycle delays.
module refsel_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/refsel_core.sv
// Selection decision. Priority: primary change, alarm clear, manual, automatic.
module refsel_core
  import refsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prim_s,
  input  logic       auto_s,
  input  logic       prim_chg,
  input  logic       clr_fall,
  input  logic [1:0] fail,
  output logic       sel,
  output logic       ind
);
  ref_t cur_q, nxt, prim;

  assign prim = ref_t'(prim_s);

  always_comb begin
    nxt = cur_q;
    if (prim_chg) begin
      nxt = prim;
    end else if (clr_fall) begin
      nxt = (&fail) ? REF_IN0 : prim;
    end else if (!auto_s) begin
      nxt = prim;
    end else if (cur_q == prim && fail[cur_q] && !fail[other(cur_q)]) begin
      nxt = other(cur_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= REF_IN0;
      ind   <= 1'b0;
    end else begin
      cur_q <= nxt;
      ind   <= cur_q;
    end
  end

  assign sel = cur_q;
endmodule

// File: rtl/refclk_selector.sv
module refclk_selector #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prim_sel_i,
  input  logic       auto_mode_i,
  input  logic       alarm_clr_n_i,
  input  logic [1:0] fail_i,
  output logic       mux_sel_o,
  output logic       in_use_o
);
  localparam int NSYNC = 3;
  localparam logic [NSYNC-1:0] SYNC_RST = 3'b100; // clear idles high

  logic clr_s, auto_s, prim_s;
  logic clr_d, prim_d;
  logic prim_chg, clr_fall;

  refsel_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({alarm_clr_n_i, auto_mode_i, prim_sel_i}),
    .q     ({clr_s, auto_s, prim_s})
  );

  refsel_sync #(.W(2), .STAGES(1), .RST_VAL(2'b10)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({clr_s, prim_s}),
    .q     ({clr_d, prim_d})
  );

  assign prim_chg = prim_s ^ prim_d;
  assign clr_fall = clr_d & ~clr_s;

  refsel_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .prim_s   (prim_s),
    .auto_s   (auto_s),
    .prim_chg (prim_chg),
    .clr_fall (clr_fall),
    .fail     (fail_i),
    .sel      (mux_sel_o),
    .ind      (in_use_o)
  );
endmodule

// File: rtl/refclk_selector_chk.sv
module refclk_selector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       prim_s,
  input logic       auto_s,
  input logic       prim_chg,
  input logic       clr_fall,
  input logic [1:0] fail_i,
  input logic       mux_sel_o,
  input logic       in_use_o
);
  p_indicator_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_use_o == $past(mux_sel_o));

  p_manual_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_s && !clr_fall) |=> (mux_sel_o == $past(prim_s)));

  p_auto_switch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_s && !clr_fall && !prim_chg && mux_sel_o == prim_s &&
     fail_i[prim_s] && !fail_i[~prim_s]) |=> (mux_sel_o != $past(mux_sel_o)));

  p_both_fail_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_s && &fail_i && !clr_fall && !prim_chg) |=> $stable(mux_sel_o));

  p_no_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_s && !clr_fall && !prim_chg && mux_sel_o != prim_s) |=> $stable(mux_sel_o));

  p_clear_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fall && !prim_chg && &fail_i) |=> !mux_sel_o);

  p_prim_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prim_chg |=> (mux_sel_o == $past(prim_s)));
endmodule

bind refclk_selector refclk_selector_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prim_s    (prim_s),
  .auto_s    (auto_s),
  .prim_chg  (prim_chg),
  .clr_fall  (clr_fall),
  .fail_i    (fail_i),
  .mux_sel_o (mux_sel_o),
  .in_use_o  (in_use_o)
);

// File: tb/test_refclk_selector.sv
`timescale 1ns/1ps
module test_refclk_selector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prim_sel_i = 1'b0;
  logic auto_mode_i = 1'b0;
  logic alarm_clr_n_i = 1'b1;
  logic [1:0] fail_i = 2'b00;
  logic mux_sel_o, in_use_o;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  refclk_selector i_refclk_selector (
    .clk(clk), .rst_n(rst_n), .prim_sel_i(prim_sel_i), .auto_mode_i(auto_mode_i),
    .alarm_clr_n_i(alarm_clr_n_i), .fail_i(fail_i),
    .mux_sel_o(mux_sel_o), .in_use_o(in_use_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic prim, input logic auto_m);
    @(negedge clk);
    rst_n = 1'b0; prim_sel_i = prim; auto_mode_i = auto_m;
    fail_i = 2'b00; alarm_clr_n_i = 1'b1;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(5);
  endtask

  task automatic pulse_clear();
    alarm_clr_n_i = 1'b0;
    wait_n(4);
    alarm_clr_n_i = 1'b1;
    wait_n(4);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; prim_sel_i = 1'b1;
    wait_n(2);
    check("R1 sel in reset", mux_sel_o, 1'b0);
    check("R1 ind in reset", in_use_o, 1'b0);
    rst_n = 1'b1;
    wait_n(5);
    check("R1 sel after reset", mux_sel_o, 1'b1);
    check("R1 ind after reset", in_use_o, 1'b1);
  endtask

  task automatic t_manual();
    do_reset(1'b0, 1'b0);
    fail_i = 2'b01;
    wait_n(4);
    check("R2 manual keeps failed primary 0", mux_sel_o, 1'b0);
    fail_i = 2'b00;
    prim_sel_i = 1'b1;
    wait_n(4);
    check("R3 manual primary change", mux_sel_o, 1'b1);
    fail_i = 2'b10;
    wait_n(4);
    check("R2 manual keeps failed primary 1", mux_sel_o, 1'b1);
    fail_i = 2'b00;
  endtask

  task automatic t_auto_switch_lag();
    do_reset(1'b0, 1'b1);
    fail_i = 2'b01;
    wait_n(1);
    check("R4 switch to secondary", mux_sel_o, 1'b1);
    check("R7 indicator not yet moved", in_use_o, 1'b0);
    wait_n(1);
    check("R7 indicator follows", in_use_o, 1'b1);
    fail_i = 2'b00;
    wait_n(5);
    check("R6 no fallback on recovery", mux_sel_o, 1'b1);
    pulse_clear();
    check("R8 clear restores primary", mux_sel_o, 1'b0);
    check("R8 indicator restored", in_use_o, 1'b0);
  endtask

  task automatic t_secondary_bad();
    do_reset(1'b1, 1'b1);
    fail_i = 2'b11;
    wait_n(5);
    check("R5 both failed holds", mux_sel_o, 1'b1);
    pulse_clear();
    check("R9 clear with both failed picks 0", mux_sel_o, 1'b0);
    check("R10 rising clear edge no effect", mux_sel_o, 1'b0);
    fail_i = 2'b00;
    wait_n(2);
  endtask

  task automatic t_auto_prim_change();
    do_reset(1'b1, 1'b1);
    fail_i = 2'b10;
    wait_n(2);
    check("R4 switch from 1 to 0", mux_sel_o, 1'b0);
    fail_i = 2'b00;
    prim_sel_i = 1'b0;
    wait_n(5);
    check("R3 auto primary change stays 0", mux_sel_o, 1'b0);
    prim_sel_i = 1'b1;
    wait_n(5);
    check("R3 auto primary change to 1", mux_sel_o, 1'b1);
    check("R7 indicator matches after change", in_use_o, 1'b1);
  endtask

  initial begin
    t_reset();
    t_manual();
    t_auto_switch_lag();
    t_secondary_bad();
    t_auto_prim_change();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule